// File: doc/BRIEF.md
# G.711 Companding Encoder

This block sits on the capture side of an audio path. It takes one 16-bit two's-complement sample per valid strobe and turns it into an 8-bit logarithmic code, using either the μ-law or the A-law rule. A 2-bit mode input picks the rule, or passes the sample through untouched. Companded codes leave the block left-aligned in a 16-bit word. The low byte of that word is zero, so a serializer that ships only the top eight bits needs no further alignment.

The datapath is a two-stage pipeline and accepts a new sample on every cycle. The first stage forms the sign and the magnitudes. For μ-law it also adds the bias and applies the clip. The second stage searches for the segment, slices out the mantissa, applies the rule's bit inversion and registers the word. The mode travels through the pipe with its own sample, so the rule may change from one sample to the next.

Top module: `pcm_compand_enc`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_word` is 0x0000 until the first sample has passed through the pipe.
- R2: A sample presented with `in_valid` high on clock edge k appears with `out_valid` high just after edge k+2. `out_valid` is low in every other cycle. Samples on consecutive cycles leave the block on consecutive cycles.
- R3: Mode 2'b00 (linear) and mode 2'b01 (reserved) both return the input sample unchanged in `out_word`.
- R4: In mode 2'b10 (μ-law) and mode 2'b11 (A-law), the 8-bit code occupies `out_word[15:8]` and `out_word[7:0]` is 0.
- R5: μ-law works on the 14-bit value in `in_sample[15:2]`. It takes the magnitude, adds 33 and clips the sum to 8191. The segment is the position of the leading one among bits 12..5 of that sum, minus 5. The mantissa is the four bits just below the leading one. The code {negative, segment, mantissa} then has all eight bits inverted. For example, input 0 gives 0xFF and input 4000 gives 0xAF.
- R6: μ-law boundary and extreme cases: 0x7FFF gives 0x80. The most negative input 0x8000 saturates to magnitude 8191 and gives 0x00. 0xFFFF gives 0x7E. 120 gives 0xF0 (top of segment 0) and 124 gives 0xEF (bottom of segment 1).
- R7: A-law works on the 13-bit value in `in_sample[15:3]`. The magnitude is the value itself, or its bitwise complement when the value is negative, which gives 12 bits. Below 32 the segment is 0 and the mantissa is magnitude bits 4:1. At 32 and above, the segment is the leading-one position minus 4 and the mantissa is the four bits below the leading one. The code {non-negative, segment, mantissa} is XORed with 0x55. For example, input 8000 gives 0x8A.
- R8: A-law boundary and extreme cases: 0 gives 0xD5, 0xFFFF gives 0x55, 0x7FFF gives 0xAA and 0x8000 gives 0x2A. 248 gives 0xDA (top of segment 0) and 256 gives 0xC5 (bottom of segment 1).
- R9: In any cycle where `out_valid` is low, `out_word` keeps its previous value, whatever the inputs do.
- R10: Each sample is encoded with the mode presented alongside it, even when the mode changes on every cycle of a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Linear two's-complement sample |
| mode | input | 2 | 00 linear, 01 reserved (linear), 10 μ-law, 11 A-law |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 16 | Companded code in the top byte, or the linear sample |

## Verification
The assertions check four properties on every cycle against the inputs two cycles earlier:

- the two-cycle latency of the strobe;
- the linear pass-through;
- the zero low byte in companded modes;
- the A-law sign bit, together with the hold of the output word between valid samples.

Only the bench scenarios can show that the codes themselves are correct. These cover the segment boundaries, the bias and clip, the saturation of the most negative input, and the two inversion patterns. The bench also runs a back-to-back stream with a mode that changes per sample and compares it against a bench-side model of the rules.

// File: rtl/g711_enc_pkg.sv
package g711_enc_pkg;

    typedef enum logic [1:0] {
        CM_LINEAR = 2'b00,
        CM_RSVD   = 2'b01,
        CM_MULAW  = 2'b10,
        CM_ALAW   = 2'b11
    } comp_mode_e;

    localparam int CODE_W    = 8;
    localparam int MU_IN_W   = 14;
    localparam int MU_MAG_W  = 13;
    localparam int A_MAG_W   = 12;
    localparam int MU_BIAS   = 33;
    localparam int MU_MAX    = (1 << MU_MAG_W) - 1;
    localparam int SEG_W     = 3;
    localparam int MANT_W    = 4;
    localparam int MU_SEG_LO = 5;
    localparam int A_SEG_LO  = 5;
    localparam logic [CODE_W-1:0] A_XOR_MASK = 8'h55;

endpackage

// File: rtl/cmp_front.sv
module cmp_front
    import g711_enc_pkg::*;
(
    input  logic [MU_IN_W-1:0]  mu_in,
    output logic                neg,
    output logic [MU_MAG_W-1:0] mu_biased,
    output logic [A_MAG_W-1:0]  a_mag
);
    logic [MU_IN_W-1:0] mu_abs;
    logic [MU_IN_W-1:0] mu_sat;
    logic [MU_IN_W-1:0] mu_sum;

    always_comb begin
        neg    = mu_in[MU_IN_W-1];
        mu_abs = neg ? (~mu_in + MU_IN_W'(1)) : mu_in;
        mu_sat = (mu_abs > MU_IN_W'(MU_MAX)) ? MU_IN_W'(MU_MAX) : mu_abs;
        mu_sum = mu_sat + MU_IN_W'(MU_BIAS);
        mu_biased = (mu_sum > MU_IN_W'(MU_MAX)) ? MU_MAG_W'(MU_MAX)
                                               : mu_sum[MU_MAG_W-1:0];
        a_mag = neg ? ~mu_in[MU_IN_W-2:1] : mu_in[MU_IN_W-2:1];
    end
endmodule

// File: rtl/cmp_mu_code.sv
module cmp_mu_code
    import g711_enc_pkg::*;
(
    input  logic                neg,
    input  logic [MU_MAG_W-1:0] biased,
    output logic [CODE_W-1:0]   code
);
    logic [SEG_W-1:0]  seg;
    logic [MANT_W-1:0] mant;

    always_comb begin
        seg = '0;
        for (int i = MU_SEG_LO; i < MU_MAG_W; i++) begin
            if (biased[i]) seg = SEG_W'(i - MU_SEG_LO);
        end
        mant = MANT_W'(biased >> ({1'b0, seg} + 4'd1));
        code = ~{neg, seg, mant};
    end
endmodule

// File: rtl/cmp_a_code.sv
module cmp_a_code
    import g711_enc_pkg::*;
(
    input  logic               neg,
    input  logic [A_MAG_W-1:0] mag,
    output logic [CODE_W-1:0]  code
);
    logic [SEG_W-1:0]  seg;
    logic [3:0]        shamt;
    logic [MANT_W-1:0] mant;

    always_comb begin
        seg = '0;
        for (int i = A_SEG_LO; i < A_MAG_W; i++) begin
            if (mag[i]) seg = SEG_W'(i - A_SEG_LO + 1);
        end
        shamt = (seg == '0) ? 4'd1 : {1'b0, seg};
        mant  = MANT_W'(mag >> shamt);
        code  = {~neg, seg, mant} ^ A_XOR_MASK;
    end
endmodule

// File: rtl/pcm_compand_enc.sv
module pcm_compand_enc
    import g711_enc_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [1:0]          mode,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_word
);
    localparam int PAD_W = SAMPLE_W - CODE_W;

    typedef struct packed {
        logic                vld;
        comp_mode_e          mode;
        logic                neg;
        logic [MU_MAG_W-1:0] mu_b;
        logic [A_MAG_W-1:0]  a_m;
        logic [SAMPLE_W-1:0] lin;
    } front_t;

    typedef struct packed {
        front_t              f;
        logic                vld;
        logic [SAMPLE_W-1:0] word;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                neg_c;
    logic [MU_MAG_W-1:0] mu_b_c;
    logic [A_MAG_W-1:0]  a_m_c;
    logic [CODE_W-1:0]   mu_code, a_code;

    cmp_front u_front (
        .mu_in     (in_sample[SAMPLE_W-1 -: MU_IN_W]),
        .neg       (neg_c),
        .mu_biased (mu_b_c),
        .a_mag     (a_m_c)
    );

    cmp_mu_code u_mu (
        .neg    (st_q.f.neg),
        .biased (st_q.f.mu_b),
        .code   (mu_code)
    );

    cmp_a_code u_a (
        .neg  (st_q.f.neg),
        .mag  (st_q.f.a_m),
        .code (a_code)
    );

    always_comb begin
        st_d        = st_q;
        st_d.f.vld  = in_valid;
        if (in_valid) begin
            st_d.f.mode = comp_mode_e'(mode);
            st_d.f.neg  = neg_c;
            st_d.f.mu_b = mu_b_c;
            st_d.f.a_m  = a_m_c;
            st_d.f.lin  = in_sample;
        end
        st_d.vld = st_q.f.vld;
        if (st_q.f.vld) begin
            unique case (st_q.f.mode)
                CM_MULAW: st_d.word = {mu_code, PAD_W'(0)};
                CM_ALAW:  st_d.word = {a_code, PAD_W'(0)};
                default:  st_d.word = st_q.f.lin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

    // Cycles since reset, so that two-deep history checks start clean.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R3
    linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid && !$past(mode[1], 2))
            |-> (out_word == $past(in_sample, 2)));

    // R4
    low_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid && $past(mode[1], 2))
            |-> (out_word[PAD_W-1:0] == '0));

    // R7
    alaw_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid && $past(mode, 2) == 2'b11)
            |-> (out_word[SAMPLE_W-1] == !$past(in_sample[SAMPLE_W-1], 2)));

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && !$past(in_valid, 2)) |-> $stable(out_word));

endmodule

// File: tb/sim_pcm_compand_enc.sv
`timescale 1ns/1ps
module sim_pcm_compand_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [1:0]  mode = 2'b00;
    logic        out_valid;
    logic [15:0] out_word;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    pcm_compand_enc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_sample(in_sample), .mode(mode),
        .out_valid(out_valid), .out_word(out_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mu_ref(input logic [15:0] s);
        int v, x, mag, b, seg, mant, code;
        bit n;
        v = $signed(s);
        x = v >>> 2;
        n = (x < 0);
        mag = n ? -x : x;
        if (mag > 8191) mag = 8191;
        b = mag + 33;
        if (b > 8191) b = 8191;
        seg = 0;
        while (seg < 7 && b >= (64 << seg)) seg++;
        mant = (b >> (seg + 1)) & 15;
        code = (n ? 128 : 0) | (seg << 4) | mant;
        return 8'(~code);
    endfunction

    function automatic logic [7:0] a_ref(input logic [15:0] s);
        int v, x, mag, seg, mant, code;
        bit n;
        v = $signed(s);
        x = v >>> 3;
        n = (x < 0);
        mag = n ? (-x - 1) : x;
        if (mag < 32) begin
            seg = 0;
            mant = (mag >> 1) & 15;
        end else begin
            seg = 1;
            while (seg < 7 && mag >= (32 << seg)) seg++;
            mant = (mag >> seg) & 15;
        end
        code = (n ? 0 : 128) | (seg << 4) | mant;
        return 8'(code ^ 8'h55);
    endfunction

    function automatic logic [15:0] word_ref(input logic [15:0] s, input logic [1:0] m);
        case (m)
            2'b10:   return {mu_ref(s), 8'h00};
            2'b11:   return {a_ref(s), 8'h00};
            default: return s;
        endcase
    endfunction

    // Sends one isolated sample and returns the output word two edges later.
    task automatic send_one(input logic [15:0] s, input logic [1:0] m, output logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_sample = s; mode = m;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 one cycle early", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        chk("R2 valid at two", {15'd0, out_valid}, 16'd1);
        w = out_word;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {15'd0, out_valid}, 16'd0);
        chk("R1 word in reset", out_word, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", {15'd0, out_valid}, 16'd0);
        chk("R1 word after reset", out_word, 16'h0000);
    endtask

    task automatic t_linear();
        logic [15:0] w;
        send_one(16'h8001, 2'b00, w); chk("R3 linear", w, 16'h8001);
        send_one(16'h1234, 2'b01, w); chk("R3 reserved", w, 16'h1234);
        send_one(16'h7FFF, 2'b01, w); chk("R3 reserved max", w, 16'h7FFF);
    endtask

    task automatic t_mulaw();
        logic [15:0] w;
        send_one(16'd0, 2'b10, w);    chk("R5 mu zero", w, 16'hFF00);
        send_one(16'd4000, 2'b10, w); chk("R5 mu 4000", w, 16'hAF00);
        chk("R4 mu low byte", {8'h00, w[7:0]}, 16'h0000);
        send_one(16'h7FFF, 2'b10, w); chk("R6 mu max", w, 16'h8000);
        send_one(16'h8000, 2'b10, w); chk("R6 mu min sat", w, 16'h0000);
        send_one(16'hFFFF, 2'b10, w); chk("R6 mu minus one", w, 16'h7E00);
        send_one(16'd120, 2'b10, w);  chk("R6 mu seg0 top", w, 16'hF000);
        send_one(16'd124, 2'b10, w);  chk("R6 mu seg1 bottom", w, 16'hEF00);
    endtask

    task automatic t_alaw();
        logic [15:0] w;
        send_one(16'd8000, 2'b11, w); chk("R7 a 8000", w, 16'h8A00);
        send_one(16'd0, 2'b11, w);    chk("R8 a zero", w, 16'hD500);
        send_one(16'hFFFF, 2'b11, w); chk("R8 a minus one", w, 16'h5500);
        send_one(16'h7FFF, 2'b11, w); chk("R8 a max", w, 16'hAA00);
        send_one(16'h8000, 2'b11, w); chk("R8 a min", w, 16'h2A00);
        send_one(16'd248, 2'b11, w);  chk("R8 a seg0 top", w, 16'hDA00);
        send_one(16'd256, 2'b11, w);  chk("R8 a seg1 bottom", w, 16'hC500);
        chk("R4 a low byte", {8'h00, w[7:0]}, 16'h0000);
    endtask

    task automatic t_hold();
        logic [15:0] w;
        send_one(16'h4321, 2'b10, w);
        for (int i = 0; i < 4; i++) begin
            in_sample = 16'(16'h1111 * (i + 3));
            mode = 2'(i);
            @(negedge clk);
            chk("R9 idle valid", {15'd0, out_valid}, 16'd0);
            chk("R9 idle hold", out_word, w);
        end
    endtask

    task automatic t_stream();
        localparam int N = 300;
        logic [15:0] exp_w [N];
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R2 stream valid", {15'd0, out_valid}, 16'd1);
                chk("R10 stream word", out_word, exp_w[i-2]);
            end
            if (i < N) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                in_valid  = 1'b1;
                in_sample = (i % 7 == 0) ? {lfsr[15], 15'(lfsr >> (i % 13))} : lfsr;
                mode      = 2'((i * 3 + 1) % 4);
                exp_w[i]  = word_ref(in_sample, mode);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 stream end", {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_linear();
        t_mulaw();
        t_alaw();
        t_hold();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule